// File: doc/BRIEF.md
# Banked Work-Group Scratchpad

A shared on-chip scratchpad for a pipelined compute datapath. Several request ports reach the same word array at once. Every concurrently running work-group gets its own private copy of that array. The storage is cut into word-wide banks, and the bank count is the port count rounded up to a power of two. The low bits of a word address pick the bank, so ports working on neighbouring words normally proceed in parallel.

When two or more ports aim at the same bank in one cycle, a rotating arbiter for that bank accepts one of them. The others see `req_ready` low and keep their request asserted until they are accepted. The caller supplies the low bits of the work-group identifier with every request. Those bits become the top bits of the bank row, so each resident work-group owns a disjoint region. A load returns its word on the same port exactly one cycle after acceptance. A store produces no response.

Top module: `wg_scratchpad`

## Requirements
- R1: Each request moves one full DW-bit word. The byte offset is not part of the address. A word stored through any port can be read back through any other port.
- R2: The bank count is 2^ceil(log2 PORTS), which gives 4 banks for 3 ports. The bank is `req_addr[BSEL-1:0]`, and `req_addr[AW-1:BSEL]` selects the row inside that bank.
- R3: In a cycle where every valid port targets a different bank, all valid ports see `req_ready` high.
- R4: In any cycle, at most one port is accepted per bank. The other valid ports aimed at that bank see `req_ready` low.
- R5: Each bank has a rotating priority pointer, which is port 0 after reset. The search for a requester starts at the pointer and moves upward through the port numbers, wrapping past the last port. After a grant, the pointer moves to the winner plus one, modulo PORTS.
- R6: Exactly one cycle after a read is accepted, that port raises `rsp_valid` for one cycle with the stored word. An accepted write produces no response.
- R7: The work-group field `req_wg` (the low log2 WG_SLOTS bits of the ID) forms the most significant part of the row. The same address under different work-group values refers to different words.
- R8: A port without `req_valid` never shows `req_ready`. After reset, no `rsp_valid` is high until a read has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | PORTS | Per-port request present |
| req_write | input | PORTS | Per-port store (1) or load (0) |
| req_addr | input | PORTS*AW | Per-port word address, port p at bits [p*AW +: AW] |
| req_wg | input | PORTS*SW | Per-port low work-group ID bits |
| req_wdata | input | PORTS*DW | Per-port store word |
| req_ready | output | PORTS | Per-port acceptance this cycle |
| rsp_valid | output | PORTS | Per-port load data valid |
| rsp_rdata | output | PORTS*DW | Per-port load data |

## Verification
The bench builds the block with 3 ports, an 8-word array and 4 work-group slots. This gives 4 banks and leaves one bank that no port maps to by default, so the rounding up of the bank count is visible. With 3 ports contending on a single bank, the bench can observe a full rotation of the priority pointer, including its wrap from the last port back to the first. Two work-group bits allow one address to hold four distinct words.

// File: rtl/wg_scratchpad.sv
`timescale 1ns/1ps
module wg_scratchpad #(
  parameter int PORTS    = 3,
  parameter int WORDS    = 8,
  parameter int WG_SLOTS = 4,
  parameter int DW       = 32,
  localparam int BSEL  = (PORTS > 1) ? $clog2(PORTS) : 1,
  localparam int NB    = 1 << BSEL,
  localparam int AW    = $clog2(WORDS),
  localparam int SW    = (WG_SLOTS > 1) ? $clog2(WG_SLOTS) : 1,
  localparam int ROWW  = AW - BSEL,
  localparam int LW    = SW + ROWW,
  localparam int DEPTH = 1 << LW,
  localparam int PW    = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PORTS-1:0]    req_valid,
  input  logic [PORTS-1:0]    req_write,
  input  logic [PORTS*AW-1:0] req_addr,
  input  logic [PORTS*SW-1:0] req_wg,
  input  logic [PORTS*DW-1:0] req_wdata,
  output logic [PORTS-1:0]    req_ready,
  output logic [PORTS-1:0]    rsp_valid,
  output logic [PORTS*DW-1:0] rsp_rdata
);

  logic [BSEL-1:0]  pbank [PORTS];
  logic [LW-1:0]    prow  [PORTS];
  logic [DW-1:0]    pdata [PORTS];
  logic [PORTS-1:0] want  [NB];
  logic [NB-1:0]    gnt_any;
  logic [PW-1:0]    gnt_port [NB];
  logic [PW-1:0]    rr [NB];
  logic [DW-1:0]    mem [NB][DEPTH];
  logic [DW-1:0]    rdata_q [PORTS];

  always_comb begin
    for (int p = 0; p < PORTS; p++) begin
      pbank[p] = req_addr[p*AW +: BSEL];
      prow[p]  = {req_wg[p*SW +: SW], req_addr[p*AW+BSEL +: ROWW]};
      pdata[p] = req_wdata[p*DW +: DW];
    end
  end

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      for (int p = 0; p < PORTS; p++)
        want[b][p] = req_valid[p] && (pbank[p] == BSEL'(b));
      gnt_any[b]  = 1'b0;
      gnt_port[b] = '0;
      for (int k = 0; k < PORTS; k++) begin
        int idx;
        idx = int'(rr[b]) + k;
        if (idx >= PORTS) idx = idx - PORTS;
        if (!gnt_any[b] && want[b][idx]) begin
          gnt_any[b]  = 1'b1;
          gnt_port[b] = PW'(idx);
        end
      end
    end
  end

  genvar gp;
  generate
    for (gp = 0; gp < PORTS; gp++) begin : g_port
      assign req_ready[gp] = req_valid[gp] && gnt_any[pbank[gp]] &&
                             (gnt_port[pbank[gp]] == PW'(gp));
      assign rsp_rdata[gp*DW +: DW] = rdata_q[gp];

      a_r8_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid[gp] |-> !req_ready[gp]);
      a_r6_read_returns: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready[gp] && !req_write[gp]) |=> rsp_valid[gp]);
      a_r6_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready[gp] && !req_write[gp]) |=> !rsp_valid[gp]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) rr[b] <= '0;
      rsp_valid <= '0;
    end else begin
      for (int b = 0; b < NB; b++)
        if (gnt_any[b])
          rr[b] <= (gnt_port[b] == PW'(PORTS-1)) ? '0 : gnt_port[b] + 1'b1;
      for (int p = 0; p < PORTS; p++)
        rsp_valid[p] <= req_ready[p] && !req_write[p];
    end
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < NB; b++)
      if (gnt_any[b] && req_write[gnt_port[b]])
        mem[b][prow[gnt_port[b]]] <= pdata[gnt_port[b]];
    for (int p = 0; p < PORTS; p++)
      if (req_ready[p] && !req_write[p])
        rdata_q[p] <= mem[pbank[p]][prow[p]];
  end

  logic [PORTS-1:0] taken [NB];
  logic             distinct;
  always_comb begin
    distinct = 1'b1;
    for (int b = 0; b < NB; b++)
      for (int p = 0; p < PORTS; p++)
        taken[b][p] = req_ready[p] && (pbank[p] == BSEL'(b));
    for (int i = 0; i < PORTS; i++)
      for (int j = i + 1; j < PORTS; j++)
        if (req_valid[i] && req_valid[j] && pbank[i] == pbank[j]) distinct = 1'b0;
  end

  genvar gb;
  generate
    for (gb = 0; gb < NB; gb++) begin : g_bank
      a_r4_one_per_bank: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(taken[gb]));
    end
  endgenerate

  a_r3_distinct_all_served: assert property (@(posedge clk) disable iff (!rst_n)
    distinct |-> ((req_ready | ~req_valid) == {PORTS{1'b1}}));

endmodule

// File: tb/wg_scratchpad_test.sv
`timescale 1ns/1ps
module wg_scratchpad_test;
  localparam int P = 3, AW = 3, SW = 2, DW = 32;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic          v [P];
  logic          w [P];
  logic [AW-1:0] a [P];
  logic [SW-1:0] g [P];
  logic [DW-1:0] d [P];
  logic [P-1:0]    req_valid, req_write, req_ready, rsp_valid;
  logic [P*AW-1:0] req_addr;
  logic [P*SW-1:0] req_wg;
  logic [P*DW-1:0] req_wdata, rsp_rdata;

  always_comb
    for (int p = 0; p < P; p++) begin
      req_valid[p] = v[p]; req_write[p] = w[p];
      req_addr[p*AW +: AW] = a[p]; req_wg[p*SW +: SW] = g[p];
      req_wdata[p*DW +: DW] = d[p];
    end

  wg_scratchpad #(.PORTS(3), .WORDS(8), .WG_SLOTS(4), .DW(32)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wg(req_wg), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata));

  int nchk = 0, nfail = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    for (int p = 0; p < P; p++) begin
      v[p] = 0; w[p] = 0; a[p] = '0; g[p] = '0; d[p] = '0;
    end
  endtask

  task automatic setp(input int p, input bit wr, input int ad, input int wg, input logic [DW-1:0] dat);
    v[p] = 1; w[p] = wr; a[p] = AW'(ad); g[p] = SW'(wg); d[p] = dat;
  endtask

  task automatic single_write(input int p, input int ad, input int wg, input logic [DW-1:0] dat);
    @(negedge clk); idle(); setp(p, 1, ad, wg, dat); #1;
    chk(req_ready[p], "R3 lone write accepted", req_ready, 1);
    @(posedge clk); @(negedge clk); idle(); #1;
    chk(rsp_valid == 0, "R6 write gives no response", rsp_valid, 0);
  endtask

  task automatic single_read(input int p, input int ad, input int wg, input logic [DW-1:0] exp, input string tag);
    @(negedge clk); idle(); setp(p, 0, ad, wg, '0); #1;
    chk(req_ready[p], "R3 lone read accepted", req_ready, 1);
    @(posedge clk); @(negedge clk); idle(); #1;
    chk(rsp_valid[p], "R6 read response valid", rsp_valid, 1 << p);
    chk(rsp_rdata[p*DW +: DW] == exp, tag, rsp_rdata[p*DW +: DW], exp);
  endtask

  task automatic t_reset();
    @(negedge clk); idle(); #1;
    chk(req_ready == 0, "R8 no ready without valid", req_ready, 0);
    chk(rsp_valid == 0, "R8 no response after reset", rsp_valid, 0);
  endtask

  task automatic t_write_read();
    single_write(0, 6, 2, 32'hCAFE_0006);
    single_read(2, 6, 2, 32'hCAFE_0006, "R1 word read back on other port");
    @(posedge clk); @(negedge clk); #1;
    chk(rsp_valid == 0, "R6 response lasts one cycle", rsp_valid, 0);
  endtask

  task automatic t_parallel();
    @(negedge clk); idle();
    for (int p = 0; p < P; p++) setp(p, 1, p, 0, 32'h5000 + p);
    #1; chk(req_ready == 3'b111, "R3 R2 distinct-bank writes together", req_ready, 7);
    @(posedge clk); @(negedge clk); idle();
    setp(0, 0, 2, 0, '0); setp(1, 0, 0, 0, '0); setp(2, 0, 1, 0, '0);
    #1; chk(req_ready == 3'b111, "R3 distinct-bank reads together", req_ready, 7);
    @(posedge clk); @(negedge clk); idle(); #1;
    chk(rsp_valid == 3'b111, "R6 parallel responses", rsp_valid, 7);
    chk(rsp_rdata[0 +: DW] == 32'h5002, "R1 port0 data", rsp_rdata[0 +: DW], 32'h5002);
    chk(rsp_rdata[DW +: DW] == 32'h5000, "R1 port1 data", rsp_rdata[DW +: DW], 32'h5000);
    chk(rsp_rdata[2*DW +: DW] == 32'h5001, "R1 port2 data", rsp_rdata[2*DW +: DW], 32'h5001);
  endtask

  task automatic contend(input logic [P-1:0] mask_in, input bit wr, input int e0, input int e1, input int e2, input string tag);
    logic [P-1:0] mask;
    int exp [3];
    exp[0] = e0; exp[1] = e1; exp[2] = e2;
    mask = mask_in;
    for (int s = 0; s < 3; s++) begin
      if (mask != 0) begin
        int win;
        @(negedge clk); idle();
        for (int p = 0; p < P; p++)
          if (mask[p]) setp(p, wr, 3, p, 32'hA000 + p);
        #1;
        chk($countones(req_ready) == 1, {"R4 one grant per bank ", tag}, req_ready, exp[s]);
        win = -1;
        for (int p = 0; p < P; p++) if (req_ready[p]) win = p;
        chk(win == exp[s], {"R5 rotation order ", tag}, win, exp[s]);
        @(posedge clk);
        if (win >= 0) mask[win] = 0;
      end
    end
    @(negedge clk); idle();
  endtask

  task automatic t_arbitration();
    contend(3'b111, 1, 0, 1, 2, "A");
    for (int p = 0; p < P; p++)
      single_read(p, 3, p, 32'hA000 + p, "R7 contended write stored per group");
    contend(3'b110, 0, 1, 2, -1, "B");
    contend(3'b010, 0, 1, -1, -1, "C");
    contend(3'b101, 0, 2, 0, -1, "D wrap");
  endtask

  task automatic t_groups();
    single_write(0, 5, 0, 32'h1111);
    single_write(1, 5, 3, 32'h3333);
    single_write(2, 5, 1, 32'h2222);
    single_read(0, 5, 3, 32'h3333, "R7 group 3 copy");
    single_read(1, 5, 0, 32'h1111, "R7 group 0 copy untouched");
    single_read(2, 5, 1, 32'h2222, "R7 group 1 copy");
    single_read(0, 1, 0, 32'h5001, "R2 row bit separates addr 1 from 5");
  endtask

  initial begin
    #200000;
    nfail++; nchk++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    t_reset();
    rst_n = 1;
    t_reset();
    t_write_read();
    t_parallel();
    t_arbitration();
    t_groups();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule